// File: doc/BRIEF.md
# Multi-Mode Readout Trigger Generator

This block turns the hit flags of nine photomultiplier channels, one external trigger line and an internal periodic source into a single readout trigger. A mode input chooses the source. Three modes work on the hit multiplicity: a threshold mode fires when the multiplicity falls, a two-fold mode and a one-fold mode fire on a rising multiplicity and each has its own prescaler. The other two modes use the external line or the internal timer.

Each hit flag is stretched over a programmable coincidence window before the flags are counted. A trigger that the selected source accepts is held for a programmable number of clock cycles before it goes out. This lets the time and charge data of the event reach buffer memory first. While a trigger is waiting to go out, every new candidate is dropped. The output is a one-cycle pulse and a 3-bit tag that names the mode that produced it.

Top module: `trig_gen`

## Requirements
- R1: A hit flag that is high at a clock edge counts toward the multiplicity for the next max(win_len_i, 1) cycles. Another hit on the same channel reloads the window.
- R2: mode_i codes are: 0 threshold (falling), 1 two-fold, 2 one-fold, 3 external, 4 internal. Codes 5 to 7 produce no trigger from any input.
- R3: In mode 0 a candidate arises in the cycle where the multiplicity goes from at least nfold_thr_i to below nfold_thr_i. A multiplicity rise is not a candidate, and neither is a peak that stays under the threshold.
- R4: In mode 1 an event is a multiplicity rise from below 2 to 2 or more. The events are prescaled by a down-counter that passes an event when the counter is 0 and then reloads it from ps_two_i. One event in ps_two_i+1 passes, and the first event after reset passes.
- R5: In mode 2 an event is a multiplicity rise from 0 to 1 or more. The events are prescaled the same way as in R4, by a separate counter loaded from ps_one_i. A lone hit does not form a two-fold event.
- R6: In mode 3, ext_trig_i passes through two synchronizing flops and is edge-detected. A rising edge that is sampled at clock edge e0 gives a trigger pulse after edge e0+delay_i+3.
- R7: The internal source fires every period_i+1 clock cycles, whatever the mode. In mode 4, consecutive triggers are period_i+1 cycles apart, provided delay_i < period_i.
- R8: A candidate that is accepted at edge k raises trig_o after edge k+delay_i+1, for exactly one cycle. A hit-driven one-fold event therefore triggers delay_i+2 edges after the edge that samples the hit.
- R9: A candidate that arrives while a trigger is pending is dropped. This holds up to and including the edge that issues the trigger.
- R10: While trig_o is high, trig_mode_o holds the mode code that was in force at acceptance. At all other times it is 0.
- R11: During and after reset, trig_o and trig_mode_o are 0, the prescalers are at zero and no trigger is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 9 | Per-channel hit flags |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| mode_i | input | 3 | Trigger mode select |
| nfold_thr_i | input | 4 | Multiplicity threshold for mode 0 |
| win_len_i | input | 4 | Coincidence window in cycles |
| ps_two_i | input | 14 | Prescale reload for mode 1 |
| ps_one_i | input | 14 | Prescale reload for mode 2 |
| period_i | input | 20 | Internal period minus one, in cycles |
| delay_i | input | 8 | Output delay in cycles |
| trig_o | output | 1 | One-cycle trigger pulse |
| trig_mode_o | output | 3 | Mode tag of the issued trigger |

## Verification
The assertions check the following on every cycle:
- each hit stretches its channel in the next cycle;
- a prescaler reloads from its programmed value after it passes an event;
- an external edge or a timer tick lasts only one cycle;
- the pending trigger counts down one step per cycle, goes out when the count reaches zero, and lasts one cycle;
- the mode tag stays 0 between pulses.

The directed scenarios are needed for the end-to-end behaviour: the exact latency of each source, that the threshold mode fires on the fall and not on the rise, the pass/skip patterns of both prescalers, the spacing of internal triggers, the dropping of candidates while a trigger is pending, and the silence of the unused mode codes.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int MODE_W = 3;
  typedef enum logic [MODE_W-1:0] {
    MODE_NFOLD = 3'd0,
    MODE_TWO   = 3'd1,
    MODE_ONE   = 3'd2,
    MODE_EXT   = 3'd3,
    MODE_INT   = 3'd4
  } tg_mode_e;
endpackage

// File: rtl/tg_stretch.sv
module tg_stretch #(
  parameter int N_CH  = 9,
  parameter int WIN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  hit_i,
  input  logic [WIN_W-1:0] win_i,
  output logic [N_CH-1:0]  act_o
);
  logic [WIN_W-1:0] ld;
  assign ld = (win_i == '0) ? WIN_W'(1) : win_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [WIN_W-1:0] cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt <= '0;
      else if (hit_i[c])        cnt <= ld;
      else if (cnt != '0)       cnt <= cnt - WIN_W'(1);
    end
    assign act_o[c] = (cnt != '0);

    a_r1_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[c] |=> act_o[c]);
  end
endmodule

// File: rtl/tg_prescale.sv
module tg_prescale #(
  parameter int PS_W = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            ev_i,
  input  logic [PS_W-1:0] load_i,
  output logic            pass_o
);
  logic [PS_W-1:0] cnt;

  assign pass_o = en_i && ev_i && (cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt <= '0;
    else if (en_i && ev_i)  cnt <= (cnt == '0) ? load_i : cnt - PS_W'(1);
  end

  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> cnt == $past(load_i));
endmodule

// File: rtl/tg_delay.sv
module tg_delay #(
  parameter int DLY_W  = 8,
  parameter int MODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_i,
  input  logic [MODE_W-1:0] tag_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic              trig_o,
  output logic [MODE_W-1:0] tag_o
);
  logic              busy;
  logic [DLY_W-1:0]  dcnt;
  logic [MODE_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy   <= 1'b0;
      dcnt   <= '0;
      tag_q  <= '0;
      trig_o <= 1'b0;
      tag_o  <= '0;
    end else begin
      trig_o <= 1'b0;
      tag_o  <= '0;
      if (!busy) begin
        if (cand_i) begin
          busy  <= 1'b1;
          dcnt  <= delay_i;
          tag_q <= tag_i;
        end
      end else if (dcnt == '0) begin
        busy   <= 1'b0;
        trig_o <= 1'b1;
        tag_o  <= tag_q;
      end else begin
        dcnt <= dcnt - DLY_W'(1);
      end
    end
  end

  a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  a_r9_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && dcnt != '0 |=> busy && dcnt == $past(dcnt) - DLY_W'(1));
  a_r9_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && dcnt == '0 |=> trig_o && !busy);
  a_r10_tag_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_o |-> tag_o == '0);
endmodule

// File: rtl/trig_gen.sv
module trig_gen
  import tg_pkg::*;
#(
  parameter int N_CH  = 9,
  parameter int WIN_W = 4,
  parameter int PS_W  = 14,
  parameter int PER_W = 20,
  parameter int DLY_W = 8,
  localparam int CNT_W = $clog2(N_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   hit_i,
  input  logic              ext_trig_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CNT_W-1:0]  nfold_thr_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic [PS_W-1:0]   ps_two_i,
  input  logic [PS_W-1:0]   ps_one_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic              trig_o,
  output logic [MODE_W-1:0] trig_mode_o
);
  logic [N_CH-1:0]  act;
  logic [CNT_W-1:0] mult, mult_q;
  logic             nfold_ev, two_ev, one_ev, ext_ev, int_ev;
  logic             two_pass, one_pass, cand;
  logic [2:0]       ext_q;
  logic [PER_W-1:0] per_cnt;

  tg_stretch #(.N_CH(N_CH), .WIN_W(WIN_W)) u_stretch (
    .clk_i, .rst_ni, .hit_i, .win_i(win_len_i), .act_o(act)
  );

  always_comb begin
    mult = '0;
    for (int i = 0; i < N_CH; i++) mult = mult + CNT_W'(act[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mult_q <= '0;
    else         mult_q <= mult;
  end

  assign nfold_ev = (mult_q >= nfold_thr_i) && (mult < nfold_thr_i);
  assign two_ev   = (mult_q < CNT_W'(2)) && (mult >= CNT_W'(2));
  assign one_ev   = (mult_q == '0) && (mult != '0);

  tg_prescale #(.PS_W(PS_W)) u_ps_two (
    .clk_i, .rst_ni, .en_i(mode_i == MODE_TWO), .ev_i(two_ev),
    .load_i(ps_two_i), .pass_o(two_pass)
  );
  tg_prescale #(.PS_W(PS_W)) u_ps_one (
    .clk_i, .rst_ni, .en_i(mode_i == MODE_ONE), .ev_i(one_ev),
    .load_i(ps_one_i), .pass_o(one_pass)
  );

  // two-flop synchronizer plus edge-detect stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= '0;
    else         ext_q <= {ext_q[1:0], ext_trig_i};
  end
  assign ext_ev = ext_q[1] && !ext_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              per_cnt <= '0;
    else if (per_cnt == '0)   per_cnt <= period_i;
    else                      per_cnt <= per_cnt - PER_W'(1);
  end
  assign int_ev = (per_cnt == '0);

  always_comb begin
    unique case (mode_i)
      MODE_NFOLD: cand = nfold_ev;
      MODE_TWO:   cand = two_pass;
      MODE_ONE:   cand = one_pass;
      MODE_EXT:   cand = ext_ev;
      MODE_INT:   cand = int_ev;
      default:    cand = 1'b0;
    endcase
  end

  tg_delay #(.DLY_W(DLY_W), .MODE_W(MODE_W)) u_delay (
    .clk_i, .rst_ni, .cand_i(cand), .tag_i(mode_i), .delay_i,
    .trig_o, .tag_o(trig_mode_o)
  );

  a_r6_ext_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_ev |=> !ext_ev);
  a_r7_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ev && period_i != '0 |=> !int_ev);
  a_r10_tag_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> trig_mode_o <= 3'd4);
endmodule

// File: tb/tb_trig_gen.sv
module tb_trig_gen;
  localparam time CLK_P = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  hit_i = '0;
  logic        ext_trig_i = 1'b0;
  logic [2:0]  mode_i = 3'd7;
  logic [3:0]  nfold_thr_i = 4'd3;
  logic [3:0]  win_len_i = 4'd2;
  logic [13:0] ps_two_i = '0;
  logic [13:0] ps_one_i = '0;
  logic [19:0] period_i = 20'd20;
  logic [7:0]  delay_i = '0;
  logic        trig_o;
  logic [2:0]  trig_mode_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  trig_gen dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts edges after stimulus until trig_o is seen at a negedge
  task automatic wait_trig(input int max_cyc, output bit got, output int n,
                           output int tag);
    got = 0; n = 0; tag = -1;
    for (int i = 0; i < max_cyc; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      n++;
      hit_i = '0; ext_trig_i = 1'b0;
      if (trig_o) begin got = 1; tag = trig_mode_o; break; end
    end
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk(trig_o == 1'b0, "R11 trig_o in reset", trig_o, 0);
    chk(trig_mode_o == 3'd0, "R11 tag in reset", trig_mode_o, 0);
  endtask

  task automatic t_idle_modes;
    bit g; int n, t;
    for (int m = 5; m < 8; m++) begin
      mode_i = 3'(m); delay_i = 8'd1;
      ext_trig_i = 1'b1; hit_i = 9'h007;
      wait_trig(30, g, n, t);
      chk(!g, "R2 unused mode silent", g, 0);
    end
  endtask

  task automatic t_ext;
    bit g; int n, t;
    mode_i = 3'd3; delay_i = 8'd5;
    ext_trig_i = 1'b1;
    wait_trig(40, g, n, t);
    chk(g && n == 9, "R6 ext latency d=5", n, 9);
    chk(t == 3, "R10 ext tag", t, 3);
    idle(5);
    delay_i = 8'd0; ext_trig_i = 1'b1;
    wait_trig(40, g, n, t);
    chk(g && n == 4, "R8 ext latency d=0", n, 4);
    @(posedge clk_i); @(negedge clk_i);
    chk(!trig_o && trig_mode_o == 0, "R8 pulse one cycle", trig_o, 0);
    idle(5);
  endtask

  task automatic t_one;
    bit g; int n, t;
    mode_i = 3'd2; delay_i = 8'd3; win_len_i = 4'd2; ps_one_i = 14'd0;
    hit_i = 9'h001;
    wait_trig(30, g, n, t);
    chk(g && n == 6, "R5 one-fold latency", n, 6);
    chk(t == 2, "R10 one-fold tag", t, 2);
    idle(10);
    ps_one_i = 14'd2;
    for (int k = 0; k < 4; k++) begin
      hit_i = 9'h010;
      wait_trig(30, g, n, t);
      chk(g == (k == 0 || k == 3), "R5 prescale pattern", g, (k == 0 || k == 3));
    end
    idle(10);
  endtask

  task automatic t_two;
    bit g; int n, t;
    mode_i = 3'd1; delay_i = 8'd2; win_len_i = 4'd3; ps_two_i = 14'd1;
    hit_i = 9'h004;
    wait_trig(30, g, n, t);
    chk(!g, "R4 single hit not two-fold", g, 0);
    for (int k = 0; k < 3; k++) begin
      hit_i = 9'h180;
      wait_trig(30, g, n, t);
      chk(g == (k != 1), "R4 prescale pattern", g, (k != 1));
      if (k == 0) chk(n == 5 && t == 1, "R4 two-fold latency", n, 5);
    end
    idle(10);
  endtask

  task automatic t_nfold;
    bit g; int n, t;
    mode_i = 3'd0; nfold_thr_i = 4'd3; win_len_i = 4'd4; delay_i = 8'd2;
    hit_i = 9'h007;
    wait_trig(40, g, n, t);
    chk(g && n == 9, "R3 falling crossing latency", n, 9);
    chk(t == 0, "R10 nfold tag", t, 0);
    idle(10);
    hit_i = 9'h030;
    wait_trig(40, g, n, t);
    chk(!g, "R3 below threshold silent", g, 0);
    win_len_i = 4'd0; hit_i = 9'h1C0;
    wait_trig(40, g, n, t);
    chk(g && n == 6, "R1 zero window acts as one", n, 6);
    idle(10);
  endtask

  task automatic t_int;
    bit g; int n, t;
    period_i = 20'd20; delay_i = 8'd2; mode_i = 3'd4;
    wait_trig(60, g, n, t);
    chk(g && t == 4, "R7 internal fires", t, 4);
    wait_trig(60, g, n, t);
    chk(g && n == 21, "R7 internal period", n, 21);
    mode_i = 3'd7;
    idle(30);
  endtask

  task automatic t_block;
    bit g; int n, t;
    mode_i = 3'd3; delay_i = 8'd10;
    ext_trig_i = 1'b1; idle(1);
    ext_trig_i = 1'b0; idle(2);
    ext_trig_i = 1'b1; idle(1);
    ext_trig_i = 1'b0;
    wait_trig(40, g, n, t);
    chk(g, "R9 first trigger issued", g, 1);
    wait_trig(40, g, n, t);
    chk(!g, "R9 pending candidate dropped", g, 0);
    ext_trig_i = 1'b1;
    wait_trig(40, g, n, t);
    chk(g && n == 14, "R9 accepts after issue", n, 14);
    mode_i = 3'd7;
    idle(5);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R8: watchdog expired, actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2);
    t_reset;
    @(negedge clk_i); rst_ni = 1'b1;
    idle(2);
    t_reset;
    t_idle_modes;
    t_ext;
    t_one;
    t_two;
    t_nfold;
    t_int;
    t_block;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule